// File: doc/BRIEF.md
# Interrupt Edge Conditioner with Noise Filter

This block sits between a bank of general-purpose I/O pins and a parent interrupt controller. It carries up to 24 interrupt lines. Each raw pin level is first passed through a two-flop synchroniser. It may then be cleaned by a glitch filter, and is finally shaped into an interrupt request for the parent. The synchronised but unfiltered level is also brought out separately, for the ordinary data-read path.

Four registers program the block. The enable register gates each line. The mode register chooses between two behaviours for each line. In level mode the line's level is handed to the parent, which interprets it. In both-edge mode every filtered change of the line is reported as a one-cycle low pulse, which the parent sees as a falling edge. Both-edge reporting depends on the filter, so it works only on a line whose filter-enable bit is also set. A single filter period serves every line. It gives the number of clock cycles a new level must hold before the filter accepts it.

Top module: `irqc_edge_cond`

## Requirements
- R1: After reset the enable, mode and filter-enable registers read 0, the filter period reads 0xFF, and every interrupt output and level output is 0.
- R2: The register offsets are: enable at 0x90, mode at 0x94, filter-enable at 0x98 and period at 0x9C. The three per-line registers are written and read in bits [23:0] and read 0 above them. The period is written and read in bits [7:0]. Any other offset reads 0.
- R3: A line whose enable bit is 0 drives its interrupt output to 0 whatever its input does.
- R4: With enable=1, mode=0 and filter-enable=0, the interrupt output equals the raw input delayed by two clock edges.
- R5: With enable=1, mode=0 and filter-enable=1, a held input change reaches the interrupt output at the (2+P)th edge after the change. P is the period, and a period of 0 acts as 1.
- R6: With the filter enabled, an input pulse that lasts fewer than P cycles never reaches the interrupt output. A pulse that lasts P cycles does reach it.
- R7: With enable=1, mode=1 and filter-enable=1, the output idles at 1. Each filtered change, rising or falling, drives it to 0 for exactly one cycle, starting at the (2+P)th edge after the input change.
- R8: With enable=1, mode=1 and filter-enable=0, the output stays at 1 and produces no pulses.
- R9: The level output equals the raw input delayed by two edges, whatever the filter and mode settings.
- R10: One period value governs the filter of every line. Two lines that change together reach their outputs on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| line_raw_i | input | NUM_LINES | Asynchronous raw pin levels |
| line_level_o | output | NUM_LINES | Synchronised, unfiltered levels for the data path |
| irq_req_o | output | NUM_LINES | Interrupt requests toward the parent controller |

## Verification
The assertions check on every cycle the following properties. A disabled line stays quiet. The unfiltered paths match a two-edge delay of the raw pins. The filtered level moves only after the synchronised level has disagreed with it. A both-edge pulse never lasts longer than one cycle. The reset value of the period register is also checked. The exact filter latency for each period, the rejection of glitches one cycle shorter than the period, and the period being shared across lines can only be shown by the bench. It does this by sweeping periods and pulse widths and counting edges to each output change.

// File: rtl/irqc_pkg.sv
// Shared constants for the interrupt edge conditioner.
// Assumes a byte-addressed register bus of 8 address and 32 data bits.
package irqc_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int MAX_LINES = 24;
    localparam int FILT_W    = 8;

    typedef logic [ADDR_W-1:0] reg_addr_t;

    localparam reg_addr_t OFS_ENABLE = 8'h90;
    localparam reg_addr_t OFS_MODE   = 8'h94;
    localparam reg_addr_t OFS_FILTEN = 8'h98;
    localparam reg_addr_t OFS_PERIOD = 8'h9C;

    localparam logic [FILT_W-1:0] PERIOD_RST = 8'hFF;
endpackage

// File: rtl/irqc_regs.sv
// Register file for the conditioner: per-line enable, mode and
// filter-enable plus one shared filter period. Reads are combinational.
// Assumes NUM_LINES < DATA_W.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = MAX_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  reg_addr_t             bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0]  irq_enable,
    output logic [NUM_LINES-1:0]  edge_mode,
    output logic [NUM_LINES-1:0]  filt_enable,
    output logic [FILT_W-1:0]     filt_period
);
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:NUM_LINES];

    // Register writes with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_enable  <= '0;
            edge_mode   <= '0;
            filt_enable <= '0;
            filt_period <= PERIOD_RST;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_ENABLE: irq_enable  <= bus_wdata[NUM_LINES-1:0];
                OFS_MODE:   edge_mode   <= bus_wdata[NUM_LINES-1:0];
                OFS_FILTEN: filt_enable <= bus_wdata[NUM_LINES-1:0];
                OFS_PERIOD: filt_period <= bus_wdata[FILT_W-1:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer, unused bits zero
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ENABLE: bus_rdata[NUM_LINES-1:0] = irq_enable;
            OFS_MODE:   bus_rdata[NUM_LINES-1:0] = edge_mode;
            OFS_FILTEN: bus_rdata[NUM_LINES-1:0] = filt_enable;
            OFS_PERIOD: bus_rdata[FILT_W-1:0]    = filt_period;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_sync2.sv
// Two-flop synchroniser for a vector of independent asynchronous bits.
// Assumes each bit is a slow level; no bus coherency is implied.
module irqc_sync2 #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1;

    // Two register stages toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= async_i;
            sync_o <= stage1;
        end
    end
endmodule

// File: rtl/irqc_line_filter.sv
// Glitch filter for one line. The filtered level takes a new value once
// the input has disagreed with it for max(period,1) consecutive cycles.
// A one-cycle change flag marks each accepted change.
module irqc_line_filter
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_i,
    input  logic [FILT_W-1:0] period_i,
    output logic              filt_o,
    output logic              chg_o
);
    logic [FILT_W-1:0] run_cnt;
    logic [FILT_W-1:0] limit;

    // Last count value before acceptance; a period of 0 behaves as 1
    always_comb begin
        limit = (period_i == '0) ? '0 : period_i - 1'b1;
    end

    // Disagreement counter, level update and change flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            filt_o  <= 1'b0;
            chg_o   <= 1'b0;
        end else begin
            chg_o <= 1'b0;
            if (sync_i == filt_o) begin
                run_cnt <= '0;
            end else if (run_cnt >= limit) begin
                filt_o  <= sync_i;
                run_cnt <= '0;
                chg_o   <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_edge_cond.sv
// Interrupt edge conditioner top. It synchronises the raw pins, filters
// each line and shapes the per-line request: 0 when disabled, a level in
// mode 0, or an active-low one-cycle pulse per filtered change in mode 1.
// Mode 1 needs the line's filter enabled, otherwise the request idles at 1.
module irqc_edge_cond
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = MAX_LINES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NUM_LINES-1:0]  line_raw_i,
    output logic [NUM_LINES-1:0]  line_level_o,
    output logic [NUM_LINES-1:0]  irq_req_o
);
    logic [NUM_LINES-1:0] irq_enable;
    logic [NUM_LINES-1:0] edge_mode;
    logic [NUM_LINES-1:0] filt_enable;
    logic [FILT_W-1:0]    filt_period;
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] filt_lvl;
    logic [NUM_LINES-1:0] filt_chg;

    irqc_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_enable  (irq_enable),
        .edge_mode   (edge_mode),
        .filt_enable (filt_enable),
        .filt_period (filt_period)
    );

    irqc_sync2 #(.WIDTH(NUM_LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (line_raw_i),
        .sync_o  (sync_lvl)
    );

    assign line_level_o = sync_lvl;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irqc_line_filter u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_i   (sync_lvl[g]),
            .period_i (filt_period),
            .filt_o   (filt_lvl[g]),
            .chg_o    (filt_chg[g])
        );

        // Request shaping per line from enable, mode and filter choice
        always_comb begin
            if (!irq_enable[g])
                irq_req_o[g] = 1'b0;
            else if (edge_mode[g])
                irq_req_o[g] = filt_enable[g] ? ~filt_chg[g] : 1'b1;
            else
                irq_req_o[g] = filt_enable[g] ? filt_lvl[g] : sync_lvl[g];
        end
    end
endmodule

// File: rtl/irqc_edge_cond_chk.sv
// Assertion checker for irqc_edge_cond, attached through bind.
// Keeps its own two-stage delay of the raw pins for comparison.
module irqc_edge_cond_chk
    import irqc_pkg::*;
#(
    parameter int NUM_LINES = MAX_LINES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_raw_i,
    input logic [NUM_LINES-1:0] line_level_o,
    input logic [NUM_LINES-1:0] irq_req_o,
    input logic [NUM_LINES-1:0] irq_enable,
    input logic [NUM_LINES-1:0] edge_mode,
    input logic [NUM_LINES-1:0] filt_enable,
    input logic [FILT_W-1:0]    filt_period,
    input logic [NUM_LINES-1:0] filt_lvl
);
    logic [NUM_LINES-1:0] dly1, dly2;

    // Reference two-edge delay of the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly1 <= '0;
            dly2 <= '0;
        end else begin
            dly1 <= line_raw_i;
            dly2 <= dly1;
        end
    end

    p_period_init_r1: assert property (@(posedge clk)
        !rst_n |=> (filt_period == PERIOD_RST));

    p_level_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_level_o == dly2);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_enable[g] |-> !irq_req_o[g]);

        p_raw_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_enable[g] && !edge_mode[g] && !filt_enable[g]) |-> (irq_req_o[g] == dly2[g]));

        p_filter_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(filt_lvl[g]) |-> ($past(line_level_o[g]) != $past(filt_lvl[g])));

        p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(irq_req_o[g]) && irq_enable[g] && edge_mode[g] && filt_enable[g]
             && filt_period >= 2)
            |=> (irq_req_o[g] || !irq_enable[g] || !edge_mode[g] || !filt_enable[g]
                 || filt_period < 2));

        p_no_pulse_unfiltered_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_enable[g] && edge_mode[g] && !filt_enable[g]) |-> irq_req_o[g]);
    end
endmodule

bind irqc_edge_cond irqc_edge_cond_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_raw_i   (line_raw_i),
    .line_level_o (line_level_o),
    .irq_req_o    (irq_req_o),
    .irq_enable   (irq_enable),
    .edge_mode    (edge_mode),
    .filt_enable  (filt_enable),
    .filt_period  (filt_period),
    .filt_lvl     (filt_lvl)
);

// File: tb/irqc_edge_cond_tb_top.sv
// Self-checking bench: sweeps filter periods, pulse widths and modes,
// counting clock edges from each input change to the output response.
module irqc_edge_cond_tb_top;
    localparam int NL = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] raw = '0;
    logic [NL-1:0] lvl;
    logic [NL-1:0] irq;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    irqc_edge_cond #(.NUM_LINES(NL)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .line_raw_i   (raw),
        .line_level_o (lvl),
        .irq_req_o    (irq)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic obs(input int idx, input bit use_lvl);
        return use_lvl ? lvl[idx] : irq[idx];
    endfunction

    // Change one input at a negedge, return edges until the output moves
    task automatic measure(input int idx, input logic val, input bit use_lvl, output int lat);
        logic start;
        @(negedge clk);
        raw[idx] = val;
        start = obs(idx, use_lvl);
        lat = -1;
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            if (obs(idx, use_lvl) !== start) begin
                lat = k;
                break;
            end
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int lat, eff;
        bit moved, quiet;
        int l0, l20;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(8'h90, d); chk(d == 0, "R1 enable reset", d, 0);
        rd(8'h94, d); chk(d == 0, "R1 mode reset", d, 0);
        rd(8'h98, d); chk(d == 0, "R1 filter enable reset", d, 0);
        rd(8'h9C, d); chk(d == 32'hFF, "R1 period reset", d, 32'hFF);
        chk(irq == 0 && lvl == 0, "R1 outputs reset", {irq, lvl}, 0);

        // R2 register map and widths
        wr(8'h90, 32'hFFFF_FFFF); rd(8'h90, d); chk(d == 32'h00FF_FFFF, "R2 enable width", d, 32'h00FF_FFFF);
        wr(8'h94, 32'h00A5_A5A5); rd(8'h94, d); chk(d == 32'h00A5_A5A5, "R2 mode readback", d, 32'h00A5_A5A5);
        wr(8'h98, 32'h0012_3456); rd(8'h98, d); chk(d == 32'h0012_3456, "R2 filter enable readback", d, 32'h0012_3456);
        wr(8'h9C, 32'h0000_1234); rd(8'h9C, d); chk(d == 32'h34, "R2 period width", d, 32'h34);
        rd(8'h00, d); chk(d == 0, "R2 unmapped offset", d, 0);
        rd(8'h91, d); chk(d == 0, "R2 unaligned offset", d, 0);
        wr(8'h90, 0); wr(8'h94, 0); wr(8'h98, 0);

        // R3 disabled lines stay quiet; R9 data path still follows
        @(negedge clk); raw = '1;
        quiet = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk); #1;
            if (irq != 0) quiet = 1'b0;
        end
        chk(quiet, "R3 disabled lines quiet", irq, 0);
        chk(lvl == '1, "R9 level with lines disabled", lvl, 24'hFFFFFF);
        @(negedge clk); raw = '0; settle(5);

        // R4 unfiltered level path, two-edge delay
        wr(8'h90, 32'hFF_FFFF);
        @(negedge clk); raw = 24'h5A5A5A;
        @(posedge clk); #1; chk(irq == 0, "R4 not yet after one edge", irq, 0);
        @(posedge clk); #1; chk(irq == 24'h5A5A5A, "R4 pattern after two edges", irq, 24'h5A5A5A);
        @(negedge clk); raw = 24'hA5A5A5;
        @(posedge clk); @(posedge clk); #1; chk(irq == 24'hA5A5A5, "R4 second pattern", irq, 24'hA5A5A5);
        @(negedge clk); raw = '0; settle(4);

        // R5 filter latency sweep over periods (0 acts as 1)
        wr(8'h98, 32'hFF_FFFF);
        for (int p = 0; p <= 6; p++) begin
            wr(8'h9C, p);
            settle(10);
            eff = (p == 0) ? 1 : p;
            measure(3, 1'b1, 1'b0, lat);
            chk(lat == 2 + eff, "R5 rise latency", lat, 2 + eff);
            settle(10);
            measure(3, 1'b0, 1'b0, lat);
            chk(lat == 2 + eff, "R5 fall latency", lat, 2 + eff);
            settle(4);
        end

        // R9 data path bypasses the filter (period 6 still set)
        measure(7, 1'b1, 1'b1, lat);
        chk(lat == 2, "R9 level latency with filter", lat, 2);
        measure(7, 1'b0, 1'b1, lat);
        chk(lat == 2, "R9 level fall latency with filter", lat, 2);
        settle(12);

        // R6 glitch rejection sweep
        for (int p = 3; p <= 5; p += 2) begin
            wr(8'h9C, p);
            settle(10);
            for (int len = 1; len <= p; len++) begin
                @(negedge clk); raw[3] = 1'b1;
                repeat (len) @(negedge clk);
                raw[3] = 1'b0;
                moved = 1'b0;
                for (int k = 0; k < 2 * p + 6; k++) begin
                    @(posedge clk); #1;
                    if (irq[3]) moved = 1'b1;
                end
                if (len < p) chk(!moved, "R6 short glitch rejected", moved, 0);
                else         chk(moved, "R6 full-length pulse passed", moved, 1);
                settle(p + 4);
            end
        end

        // R7 both-edge pulses
        wr(8'h94, 32'hFF_FFFF);
        for (int p = 2; p <= 4; p++) begin
            wr(8'h9C, p);
            settle(10);
            chk(irq[3] == 1'b1, "R7 idle high", irq[3], 1);
            measure(3, 1'b1, 1'b0, lat);
            chk(lat == 2 + p, "R7 pulse on rise", lat, 2 + p);
            @(posedge clk); #1; chk(irq[3] == 1'b1, "R7 one-cycle low on rise", irq[3], 1);
            settle(8);
            measure(3, 1'b0, 1'b0, lat);
            chk(lat == 2 + p, "R7 pulse on fall", lat, 2 + p);
            @(posedge clk); #1; chk(irq[3] == 1'b1, "R7 one-cycle low on fall", irq[3], 1);
            settle(8);
        end

        // R8 both-edge mode without the filter gives no pulses
        wr(8'h98, 0);
        settle(4);
        quiet = 1'b1;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk); raw[3] = ~raw[3];
            for (int k = 0; k < 8; k++) begin
                @(posedge clk); #1;
                if (irq[3] !== 1'b1) quiet = 1'b0;
            end
        end
        chk(quiet, "R8 no pulse without filter", quiet, 1);

        // R10 one period shared by two lines
        wr(8'h94, 0); wr(8'h98, 32'hFF_FFFF); wr(8'h9C, 4);
        @(negedge clk); raw = '0; settle(12);
        @(negedge clk); raw[0] = 1'b1; raw[20] = 1'b1;
        l0 = -1; l20 = -1;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk); #1;
            if (l0 < 0 && irq[0]) l0 = k;
            if (l20 < 0 && irq[20]) l20 = k;
        end
        chk(l0 == 6, "R10 line 0 latency", l0, 6);
        chk(l20 == 6, "R10 line 20 latency", l20, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule